// File: doc/BRIEF.md
# Read-After-Write Interlock Stall Controller

This block guards a six-stage in-order pipeline against read-after-write hazards. The stages are fetch, decode, register fetch, execute/address, memory access and write-back. The register file is written only in write-back. The block resolves every hazard by stalling and never by forwarding. Each cycle it compares the source registers of the instruction sitting in decode against the destinations of older instructions still ahead of write-back. If an older instruction will write a register that the decoding instruction reads, the block freezes fetch and decode and sends a bubble into register fetch.

The block keeps its own copy of the control tags (valid, destination, write-enable) for the register-fetch, execute and memory stages. These tags advance one stage per clock, the same way the real pipeline registers do. Write-back does not need to be tracked. A consumer released while its producer sits in write-back reads the register file one cycle later, after the write has landed. The register-fetch tag, including the memory write-enable, is also driven out, so the datapath can use it as the register-fetch control register.

Top module: `ilk_stall_ctrl`

## Requirements
- R1: While reset is low, and in the cycle after it is released with no valid instruction in decode, `rf_valid_o`, `rf_rd_we_o`, `rf_mem_we_o` and all three hold outputs are 0.
- R2: A consumer decoded one cycle after its producer (source = producer destination, use flag set, producer write-enable set) is held in decode for exactly 3 cycles. It shows up in register fetch (`rf_valid_o`=1, `rf_rd_o` = its destination) in the cycle after the producer's write-back cycle.
- R3: The number of hold cycles is 4 minus the issue distance, floored at 0: distance 2 gives 2, distance 3 gives 1, distance 4 gives 0. With two producers in flight, the nearest one sets the count.
- R4: The second source field is compared in the same way as the first. A match on source 2 alone gives the same 3-cycle hold.
- R5: A source field whose use flag is 0 never causes a hold, even if it matches an in-flight destination.
- R6: An older instruction with its register write-enable at 0 (for example a store) never counts as a producer, whatever its destination field holds.
- R7: In every cycle that follows a held cycle, the register-fetch tag is a bubble: `rf_valid_o`, `rf_rd_we_o` and `rf_mem_we_o` are all 0.
- R8: `fetch_hold_o`, `dec_hold_o` and `rf_bubble_o` are always equal.
- R9: When `dec_valid_i` is 0 there is no hold, whatever the source fields hold. The slot enters register fetch with `rf_valid_o`=0, and the producers already in flight keep advancing.
- R10: A store consumer (register write-enable 0, memory write-enable 1) that reads a register written by the instruction just ahead of it is held 3 cycles. It then enters register fetch with `rf_mem_we_o`=1 and `rf_rd_we_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dec_valid_i | input | 1 | Decode holds a real instruction |
| dec_rs1_i | input | AW | Source register 1 number |
| dec_rs1_use_i | input | 1 | Source 1 is read by the instruction |
| dec_rs2_i | input | AW | Source register 2 number |
| dec_rs2_use_i | input | 1 | Source 2 is read by the instruction |
| dec_rd_i | input | AW | Destination register number |
| dec_rd_we_i | input | 1 | Instruction writes the register file |
| dec_mem_we_i | input | 1 | Instruction writes memory |
| fetch_hold_o | output | 1 | Freeze the fetch stage |
| dec_hold_o | output | 1 | Keep the decode register unchanged |
| rf_bubble_o | output | 1 | Load a bubble into register fetch |
| rf_valid_o | output | 1 | Register-fetch tag: valid |
| rf_rd_o | output | AW | Register-fetch tag: destination |
| rf_rd_we_o | output | 1 | Register-fetch tag: register write-enable |
| rf_mem_we_o | output | 1 | Register-fetch tag: memory write-enable |

## Verification
Producer and consumer pairs are issued at distances 1 to 4. The measured hold count tells apart the comparators for each in-flight stage, and shows whether write-back is wrongly included in the comparison or whether a stage is missed. Matches on source 1 only, on source 2 only, and on two producers at once separate the two source comparators and show that the nearest producer sets the hold. Stimuli with a matching number but the use flag clear, the write-enable clear, or decode not valid each exercise one qualifier of the hazard term. A store consumer checks that the memory write-enable reaches register fetch only after the hold ends.

// File: rtl/ilk_pkg.sv
package ilk_pkg;
  // stages whose pending register write can still be missed by a register-fetch read
  typedef enum int unsigned {
    STG_RF  = 0,
    STG_EX  = 1,
    STG_MEM = 2
  } ilk_stage_e;

  localparam int unsigned ILK_PROD_STAGES = 3;
endpackage

// File: rtl/ilk_tag_pipe.sv
module ilk_tag_pipe #(
  parameter int unsigned AW    = 3,
  parameter int unsigned DEPTH = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_vld_i,
  input  logic [AW-1:0]            in_rd_i,
  input  logic                     in_we_i,
  input  logic                     bubble_i,
  output logic [DEPTH-1:0]         vld_o,
  output logic [DEPTH-1:0][AW-1:0] rd_o,
  output logic [DEPTH-1:0]         we_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_stg
    logic          nv, nwe, v_q, we_q;
    logic [AW-1:0] nrd, rd_q;

    if (g == 0) begin : g_head
      assign nv  = in_vld_i & ~bubble_i;
      assign nwe = in_vld_i & in_we_i & ~bubble_i;
      assign nrd = bubble_i ? '0 : in_rd_i;
    end else begin : g_body
      assign nv  = vld_o[g-1];
      assign nwe = we_o[g-1];
      assign nrd = rd_o[g-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        v_q  <= 1'b0;
        we_q <= 1'b0;
        rd_q <= '0;
      end else begin
        v_q  <= nv;
        we_q <= nwe;
        rd_q <= nrd;
      end
    end

    assign vld_o[g] = v_q;
    assign we_o[g]  = we_q;
    assign rd_o[g]  = rd_q;
  end
endmodule

// File: rtl/ilk_match.sv
module ilk_match #(
  parameter int unsigned AW    = 3,
  parameter int unsigned DEPTH = 3
) (
  input  logic [AW-1:0]            rs1_i,
  input  logic                     rs1_use_i,
  input  logic [AW-1:0]            rs2_i,
  input  logic                     rs2_use_i,
  input  logic [DEPTH-1:0]         vld_i,
  input  logic [DEPTH-1:0][AW-1:0] rd_i,
  input  logic [DEPTH-1:0]         we_i,
  output logic [DEPTH-1:0]         hit_o
);
  for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
    logic m1, m2;
    assign m1       = rs1_use_i & (rd_i[g] == rs1_i);
    assign m2       = rs2_use_i & (rd_i[g] == rs2_i);
    assign hit_o[g] = vld_i[g] & we_i[g] & (m1 | m2);
  end
endmodule

// File: rtl/ilk_stall_ctrl.sv
module ilk_stall_ctrl #(
  parameter  int unsigned NREGS = 8,
  parameter  int unsigned DEPTH = ilk_pkg::ILK_PROD_STAGES,
  localparam int unsigned AW    = $clog2(NREGS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          dec_valid_i,
  input  logic [AW-1:0] dec_rs1_i,
  input  logic          dec_rs1_use_i,
  input  logic [AW-1:0] dec_rs2_i,
  input  logic          dec_rs2_use_i,
  input  logic [AW-1:0] dec_rd_i,
  input  logic          dec_rd_we_i,
  input  logic          dec_mem_we_i,
  output logic          fetch_hold_o,
  output logic          dec_hold_o,
  output logic          rf_bubble_o,
  output logic          rf_valid_o,
  output logic [AW-1:0] rf_rd_o,
  output logic          rf_rd_we_o,
  output logic          rf_mem_we_o
);
  localparam int unsigned RF = int'(ilk_pkg::STG_RF);

  logic [DEPTH-1:0]         tag_vld, tag_we, hit;
  logic [DEPTH-1:0][AW-1:0] tag_rd;
  logic                     stall, rf_mem_we_q;

  ilk_tag_pipe #(.AW(AW), .DEPTH(DEPTH)) u_tags (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .in_vld_i (dec_valid_i),
    .in_rd_i  (dec_rd_i),
    .in_we_i  (dec_rd_we_i),
    .bubble_i (stall),
    .vld_o    (tag_vld),
    .rd_o     (tag_rd),
    .we_o     (tag_we)
  );

  ilk_match #(.AW(AW), .DEPTH(DEPTH)) u_match (
    .rs1_i     (dec_rs1_i),
    .rs1_use_i (dec_rs1_use_i),
    .rs2_i     (dec_rs2_i),
    .rs2_use_i (dec_rs2_use_i),
    .vld_i     (tag_vld),
    .rd_i      (tag_rd),
    .we_i      (tag_we),
    .hit_o     (hit)
  );

  assign stall = dec_valid_i & (|hit);

  // memory enable only matters in register fetch onward; the datapath carries it further
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rf_mem_we_q <= 1'b0;
    else         rf_mem_we_q <= dec_valid_i & dec_mem_we_i & ~stall;
  end

  assign fetch_hold_o = stall;
  assign dec_hold_o   = stall;
  assign rf_bubble_o  = stall;
  assign rf_valid_o   = tag_vld[RF];
  assign rf_rd_o      = tag_rd[RF];
  assign rf_rd_we_o   = tag_we[RF];
  assign rf_mem_we_o  = rf_mem_we_q;
endmodule

// File: rtl/ilk_stall_chk.sv
module ilk_stall_chk #(
  parameter int unsigned AW    = 3,
  parameter int unsigned DEPTH = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          dec_valid_i,
  input logic [AW-1:0] dec_rs1_i,
  input logic          dec_rs1_use_i,
  input logic [AW-1:0] dec_rs2_i,
  input logic          dec_rs2_use_i,
  input logic          dec_mem_we_i,
  input logic          fetch_hold_o,
  input logic          rf_valid_o,
  input logic [AW-1:0] rf_rd_o,
  input logic          rf_rd_we_o,
  input logic          rf_mem_we_o
);
  localparam int unsigned CW = $clog2(DEPTH + 2);
  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (!fetch_hold_o) run_q <= '0;
    else if (run_q <= CW'(DEPTH)) run_q <= run_q + 1'b1;
  end

  p_bubble_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hold_o |=> (!rf_valid_o && !rf_rd_we_o && !rf_mem_we_o));

  p_idle_no_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dec_valid_i |-> !fetch_hold_o);

  p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !fetch_hold_o) |=> rf_valid_o);

  p_rf_match_rs1_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_valid_o && rf_rd_we_o && dec_valid_i && dec_rs1_use_i && dec_rs1_i == rf_rd_o)
      |-> fetch_hold_o);

  p_rf_match_rs2_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rf_valid_o && rf_rd_we_o && dec_valid_i && dec_rs2_use_i && dec_rs2_i == rf_rd_o)
      |-> fetch_hold_o);

  p_unused_src_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dec_rs1_use_i && !dec_rs2_use_i) |-> !fetch_hold_o);

  p_hold_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_hold_o |-> (run_q < CW'(DEPTH)));

  p_mem_carry_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_valid_i && !fetch_hold_o && dec_mem_we_i) |=> rf_mem_we_o);
endmodule

bind ilk_stall_ctrl ilk_stall_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .dec_valid_i   (dec_valid_i),
  .dec_rs1_i     (dec_rs1_i),
  .dec_rs1_use_i (dec_rs1_use_i),
  .dec_rs2_i     (dec_rs2_i),
  .dec_rs2_use_i (dec_rs2_use_i),
  .dec_mem_we_i  (dec_mem_we_i),
  .fetch_hold_o  (fetch_hold_o),
  .rf_valid_o    (rf_valid_o),
  .rf_rd_o       (rf_rd_o),
  .rf_rd_we_o    (rf_rd_we_o),
  .rf_mem_we_o   (rf_mem_we_o)
);

// File: tb/sim_ilk_stall_ctrl.sv
module sim_ilk_stall_ctrl;
  localparam int unsigned AW = 3;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          dec_valid_i = 1'b0;
  logic [AW-1:0] dec_rs1_i = '0;
  logic          dec_rs1_use_i = 1'b0;
  logic [AW-1:0] dec_rs2_i = '0;
  logic          dec_rs2_use_i = 1'b0;
  logic [AW-1:0] dec_rd_i = '0;
  logic          dec_rd_we_i = 1'b0;
  logic          dec_mem_we_i = 1'b0;
  logic          fetch_hold_o, dec_hold_o, rf_bubble_o;
  logic          rf_valid_o, rf_rd_we_o, rf_mem_we_o;
  logic [AW-1:0] rf_rd_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  ilk_stall_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_ni),
    .dec_valid_i(dec_valid_i),
    .dec_rs1_i(dec_rs1_i), .dec_rs1_use_i(dec_rs1_use_i),
    .dec_rs2_i(dec_rs2_i), .dec_rs2_use_i(dec_rs2_use_i),
    .dec_rd_i(dec_rd_i), .dec_rd_we_i(dec_rd_we_i), .dec_mem_we_i(dec_mem_we_i),
    .fetch_hold_o(fetch_hold_o), .dec_hold_o(dec_hold_o), .rf_bubble_o(rf_bubble_o),
    .rf_valid_o(rf_valid_o), .rf_rd_o(rf_rd_o),
    .rf_rd_we_o(rf_rd_we_o), .rf_mem_we_o(rf_mem_we_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0d want %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // present one decode instruction at a negedge; return after it has left decode
  task automatic issue(input logic v, input logic [AW-1:0] s1, input logic u1,
                       input logic [AW-1:0] s2, input logic u2,
                       input logic [AW-1:0] rd, input logic we, input logic mwe,
                       output int stalls);
    bit done;
    dec_valid_i = v; dec_rs1_i = s1; dec_rs1_use_i = u1;
    dec_rs2_i = s2; dec_rs2_use_i = u2; dec_rd_i = rd;
    dec_rd_we_i = we; dec_mem_we_i = mwe;
    stalls = 0;
    done = 0;
    while (!done) begin
      #1;
      chk("R8 holds agree", int'({dec_hold_o, rf_bubble_o}), int'({fetch_hold_o, fetch_hold_o}));
      if (fetch_hold_o) begin
        stalls++;
        @(posedge clk); @(negedge clk);
        chk("R7 bubble fields", int'({rf_valid_o, rf_rd_we_o, rf_mem_we_o}), 0);
        if (stalls > 8) done = 1;
      end else begin
        @(posedge clk); @(negedge clk);
        done = 1;
      end
    end
  endtask

  task automatic nop();
    int s;
    issue(0, 0, 0, 0, 0, 0, 0, 0, s);
  endtask

  task automatic flush();
    for (int k = 0; k < 4; k++) nop();
  endtask

  task automatic prod(input logic [AW-1:0] rd);
    int s;
    issue(1, 0, 0, 0, 0, rd, 1, 0, s);
    chk("R2 producer not held", s, 0);
  endtask

  task automatic filler();
    int s;
    issue(1, 0, 0, 0, 0, 5, 1, 0, s);
  endtask

  task automatic t_reset();
    #12;
    chk("R1 reset rf tag", int'({rf_valid_o, rf_rd_we_o, rf_mem_we_o}), 0);
    chk("R1 reset holds", int'({fetch_hold_o, dec_hold_o, rf_bubble_o}), 0);
    @(negedge clk); rst_ni = 1'b1;
    @(negedge clk); #1;
    chk("R1 after release", int'({rf_valid_o, fetch_hold_o, rf_rd_we_o, rf_mem_we_o}), 0);
    @(negedge clk);
  endtask

  task automatic t_dist(input int d);
    int s;
    flush();
    prod(3);
    for (int k = 1; k < d; k++) filler();
    issue(1, 3, 1, 0, 0, 6, 1, 0, s);
    if (d == 1) begin
      chk("R2 back-to-back hold count", s, 3);
      chk("R2 consumer in rf valid", int'(rf_valid_o), 1);
      chk("R2 consumer in rf rd", int'(rf_rd_o), 6);
    end else begin
      chk("R3 distance hold count", s, (4 - d) > 0 ? 4 - d : 0);
      chk("R3 consumer in rf", int'({rf_valid_o, rf_rd_o}), int'({1'b1, 3'd6}));
    end
  endtask

  task automatic t_src2();
    int s;
    flush();
    prod(2);
    issue(1, 1, 1, 2, 1, 6, 1, 0, s);
    chk("R4 rs2 hazard", s, 3);
  endtask

  task automatic t_two_prod();
    int s;
    flush();
    prod(3);
    prod(4);
    issue(1, 3, 1, 4, 1, 6, 1, 0, s);
    chk("R3 nearest producer", s, 3);
  endtask

  task automatic t_unused();
    int s;
    flush();
    prod(4);
    issue(1, 4, 0, 4, 0, 6, 1, 0, s);
    chk("R5 unused sources", s, 0);
    chk("R5 entered rf", int'(rf_valid_o), 1);
  endtask

  task automatic t_nowe();
    int s;
    flush();
    issue(1, 0, 0, 0, 0, 3, 0, 1, s);
    issue(1, 3, 1, 3, 1, 6, 1, 0, s);
    chk("R6 non-writer ignored", s, 0);
    chk("R6 entered rf", int'(rf_valid_o), 1);
  endtask

  task automatic t_store();
    int s;
    flush();
    prod(7);
    issue(1, 0, 1, 7, 1, 0, 0, 1, s);
    chk("R10 store hold", s, 3);
    chk("R10 store tag", int'({rf_valid_o, rf_rd_we_o, rf_mem_we_o}), int'(3'b101));
  endtask

  task automatic t_invalid();
    int s;
    flush();
    prod(3);
    issue(0, 3, 1, 3, 1, 6, 1, 1, s);
    chk("R9 invalid no hold", s, 0);
    chk("R9 invalid slot", int'({rf_valid_o, rf_rd_we_o, rf_mem_we_o}), 0);
    issue(1, 3, 1, 0, 0, 6, 1, 0, s);
    chk("R9 producer kept advancing", s, 2);
  endtask

  initial begin
    #2_000_000;
    bad++;
    total++;
    $display("FAIL watchdog: got timeout want completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_dist(1);
    t_dist(2);
    t_dist(3);
    t_dist(4);
    t_src2();
    t_two_prod();
    t_unused();
    t_nowe();
    t_store();
    t_invalid();
    flush();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule